// File: doc/BRIEF.md
# MLT-3 Line Codec with Loopback and Cable-Fault Control

This block is the digital coding and control path of a twisted-pair line transceiver. On the transmit side it takes one binary bit per clock. It produces a 2-bit signed line symbol, which is either a three-level MLT-3 stream or a plain two-level binary stream. On the receive side it takes one quantised line symbol per clock. It recovers the binary data and qualifies a signal-detect flag from an amplitude-valid indication.

Three mode inputs control the paths. The first selects binary coding for both directions. The second enables a loopback, which routes the transmit bits back to the receive data output. During loopback the transmitter still sends, but always as two-level binary. The third is an active-low cable-detect input. When it is high, the block reports a wire fault: signal detect is forced low and the receive data is held static. Loopback overrides the fault. Every output is registered and has one clock of latency.

Top module: `mlt3_line_codec`

## Requirements
- R1: With `bin_mode` low and `loop_en` low, each `tx_bit`=1 moves the transmit level one step around the cycle 0, +1, 0, -1, and `tx_bit`=0 holds the level. Symbol codes are 00 = 0, 01 = +1, 11 = -1. After reset the level is 0 and the next step goes to +1.
- R2: With `bin_mode`, `loop_en` and `cable_det_n` all low, `rx_data` is 1 when the sampled `rx_sym` differs from the `rx_sym` sampled one clock earlier, and 0 otherwise. The earlier symbol is captured on every clock in every mode and resets to 00.
- R3: With `bin_mode` high and `loop_en` low, `tx_sym` is 01 for `tx_bit`=1 and 00 for `tx_bit`=0. The MLT-3 level is frozen and resumes from where it stopped.
- R4: With `bin_mode` high and `loop_en` and `cable_det_n` low, `rx_data` is 1 for any `rx_sym` other than 00.
- R5: With `loop_en` high, `rx_data` equals `tx_bit` of the previous clock, whatever `rx_sym` carries.
- R6: With `loop_en` high, `tx_sym` is two-level binary (01 or 00) whatever the value of `bin_mode`. The MLT-3 level is frozen.
- R7: A filtered detect state follows `rx_amp_ok`. It changes only after 4 consecutive samples that disagree with it, and a single agreeing sample restarts the count. The filter runs in all modes. `sig_det` shows this state when neither override is active.
- R8: With `cable_det_n` high and `loop_en` low, `sig_det` is 0 and `rx_data` is 0.
- R9: With `loop_en` high, `sig_det` is 1 even when `cable_det_n` is high.
- R10: During reset, `tx_sym` is 00, `rx_data` is 0, `sig_det` is 0 and the detect filter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bit | input | 1 | Serial transmit bit |
| rx_sym | input | 2 | Quantised receive symbol (00, 01, 11) |
| rx_amp_ok | input | 1 | Receive amplitude valid |
| bin_mode | input | 1 | 1 selects two-level binary coding, 0 selects MLT-3 |
| loop_en | input | 1 | Loopback enable |
| cable_det_n | input | 1 | Active-low cable detect; high signals a wire fault |
| tx_sym | output | 2 | Transmit line symbol |
| rx_data | output | 1 | Recovered receive bit |
| sig_det | output | 1 | Signal detect |

## Verification
A directed run of ones from reset should walk the transmit symbol through +1, 0, -1, 0 and back. Inserted zeros and binary or loopback intervals should show that the level holds and then resumes from the frozen phase. Receive streams with repeated and changing symbols separate transition decoding from nonzero decoding. Amplitude runs of exactly three and exactly four samples separate a correct filter length from a filter that is one sample off. Random mixes of loopback and fault, including both at once, check the override priority for data and detect.

// File: rtl/mlt3_codec_pkg.sv
package mlt3_codec_pkg;
  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_NEG  = 2'b11;

  // phase 0..3 maps to the level sequence 0, +1, 0, -1
  function automatic logic [1:0] phase_to_sym(input logic [1:0] ph);
    logic [1:0] s;
    case (ph)
      2'd1:    s = SYM_POS;
      2'd3:    s = SYM_NEG;
      default: s = SYM_ZERO;
    endcase
    return s;
  endfunction

  function automatic logic sym_nonzero(input logic [1:0] s);
    return s != SYM_ZERO;
  endfunction

  function automatic logic [1:0] bit_to_binary_sym(input logic b);
    return b ? SYM_POS : SYM_ZERO;
  endfunction
endpackage

// File: rtl/mlt3_tx_encoder.sv
module mlt3_tx_encoder
  import mlt3_codec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_bit,
  input  logic       force_bin,
  output logic [1:0] sym_o
);
  logic [1:0] phase_q, phase_d;
  logic [1:0] sym_q;
  logic       last_mlt_q;
  logic       advance;

  assign advance = !force_bin && tx_bit;
  assign phase_d = advance ? phase_q + 2'd1 : phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= 2'd0;
      sym_q      <= SYM_ZERO;
      last_mlt_q <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      sym_q      <= force_bin ? bit_to_binary_sym(tx_bit) : phase_to_sym(phase_d);
      last_mlt_q <= !force_bin;
    end
  end

  assign sym_o = sym_q;

  p_valid_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sym_q != 2'b10);

  p_bin_two_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    force_bin |=> (sym_q == bit_to_binary_sym($past(tx_bit))));

  p_step_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (last_mlt_q && !force_bin && tx_bit) |=> (sym_q != $past(sym_q)));

  p_zero_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (last_mlt_q && !force_bin && !tx_bit) |=> $stable(sym_q));

  p_no_rail_jump_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (last_mlt_q && !force_bin && sym_q[0]) |=> !(sym_q[0] && (sym_q != $past(sym_q))));
endmodule

// File: rtl/mlt3_rx_decoder.sv
module mlt3_rx_decoder
  import mlt3_codec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_sym,
  input  logic       bin_mode,
  input  logic       loop_en,
  input  logic       fault,
  input  logic       loop_bit,
  output logic       data_o
);
  logic [1:0] prev_q;
  logic       data_q;
  logic       sym_changed;
  logic       line_bit;

  assign sym_changed = rx_sym != prev_q;
  assign line_bit    = bin_mode ? sym_nonzero(rx_sym) : sym_changed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= SYM_ZERO;
      data_q <= 1'b0;
    end else begin
      prev_q <= rx_sym;
      if (loop_en)     data_q <= loop_bit;
      else if (fault)  data_q <= 1'b0;
      else             data_q <= line_bit;
    end
  end

  assign data_o = data_q;

  p_loop_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> (data_q == $past(loop_bit)));

  p_fault_static_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !loop_en) |=> !data_q);

  p_bin_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_mode && !loop_en && !fault && rx_sym == SYM_ZERO) |=> !data_q);
endmodule

// File: rtl/sigdet_filter.sv
module sigdet_filter #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic amp_ok,
  input  logic loop_en,
  input  logic fault,
  output logic sd_o
);
  localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          det_q, det_d;
  logic          sd_q;
  logic          mismatch;
  logic          flip;

  assign mismatch = amp_ok != det_q;
  assign flip     = mismatch && (cnt_q == LAST);
  assign det_d    = flip ? amp_ok : det_q;
  assign cnt_d    = (mismatch && !flip) ? cnt_q + CW'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      det_q <= 1'b0;
      sd_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      det_q <= det_d;
      if (loop_en)    sd_q <= 1'b1;
      else if (fault) sd_q <= 1'b0;
      else            sd_q <= det_d;
    end
  end

  assign sd_o = sd_q;

  p_loop_forces_sd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> sd_q);

  p_fault_clears_sd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !loop_en) |=> !sd_q);

  p_rise_after_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_q) |-> $past(amp_ok));

  p_fall_after_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_q) |-> !$past(amp_ok));

  p_run_resets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch |=> (cnt_q == '0));
endmodule

// File: rtl/mlt3_line_codec.sv
module mlt3_line_codec #(
  parameter int DET_RUN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_bit,
  input  logic [1:0] rx_sym,
  input  logic       rx_amp_ok,
  input  logic       bin_mode,
  input  logic       loop_en,
  input  logic       cable_det_n,
  output logic [1:0] tx_sym,
  output logic       rx_data,
  output logic       sig_det
);
  logic force_bin;
  logic wire_fault;

  assign force_bin  = bin_mode || loop_en;
  assign wire_fault = cable_det_n;

  mlt3_tx_encoder u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_bit    (tx_bit),
    .force_bin (force_bin),
    .sym_o     (tx_sym)
  );

  mlt3_rx_decoder u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_sym   (rx_sym),
    .bin_mode (bin_mode),
    .loop_en  (loop_en),
    .fault    (wire_fault),
    .loop_bit (tx_bit),
    .data_o   (rx_data)
  );

  sigdet_filter #(.RUN_LEN(DET_RUN)) u_sd (
    .clk     (clk),
    .rst_n   (rst_n),
    .amp_ok  (rx_amp_ok),
    .loop_en (loop_en),
    .fault   (wire_fault),
    .sd_o    (sig_det)
  );

  p_loop_tx_binary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> (tx_sym[1] == 1'b0 && tx_sym[0] == $past(tx_bit)));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (tx_sym == 2'b00 && !rx_data && !sig_det));
endmodule

// File: tb/mlt3_line_codec_tb.sv
module mlt3_line_codec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_bit = 1'b0;
  logic [1:0] rx_sym = 2'b00;
  logic       rx_amp_ok = 1'b0;
  logic       bin_mode = 1'b0;
  logic       loop_en = 1'b0;
  logic       cable_det_n = 1'b0;
  logic [1:0] tx_sym;
  logic       rx_data;
  logic       sig_det;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int         m_phase = 0;
  logic [1:0] m_prev = 2'b00;
  bit         m_det = 0;
  int         m_run = 0;
  logic [1:0] e_tx = 2'b00;
  logic       e_rx = 1'b0;
  logic       e_sd = 1'b0;
  string      t_tx = "R10", t_rx = "R10", t_sd = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  mlt3_line_codec u_dut (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .rx_sym(rx_sym),
    .rx_amp_ok(rx_amp_ok), .bin_mode(bin_mode), .loop_en(loop_en),
    .cable_det_n(cable_det_n), .tx_sym(tx_sym), .rx_data(rx_data), .sig_det(sig_det)
  );

  function automatic logic [1:0] level_of(int ph);
    if (ph % 2 == 0) return 2'b00;
    return (ph % 4 == 1) ? 2'b01 : 2'b11;
  endfunction

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compute what the next clock edge produces from the current inputs
  task automatic model_edge();
    if (loop_en || bin_mode) begin
      e_tx = tx_bit ? 2'b01 : 2'b00;
      t_tx = loop_en ? "R6" : "R3";
    end else begin
      if (tx_bit) m_phase = (m_phase + 1) % 4;
      e_tx = level_of(m_phase);
      t_tx = "R1";
    end
    if (loop_en)          begin e_rx = tx_bit; t_rx = "R5"; end
    else if (cable_det_n) begin e_rx = 1'b0;  t_rx = "R8"; end
    else if (bin_mode)    begin e_rx = (rx_sym != 2'b00); t_rx = "R4"; end
    else                  begin e_rx = (rx_sym != m_prev); t_rx = "R2"; end
    m_prev = rx_sym;
    if (rx_amp_ok != m_det) begin
      m_run++;
      if (m_run == 4) begin m_det = rx_amp_ok; m_run = 0; end
    end else m_run = 0;
    if (loop_en)          begin e_sd = 1'b1;  t_sd = "R9"; end
    else if (cable_det_n) begin e_sd = 1'b0;  t_sd = "R8"; end
    else                  begin e_sd = m_det; t_sd = "R7"; end
  endtask

  // called at a negedge: drive, let one edge pass, check at the next negedge
  task automatic step(input logic b, input logic [1:0] s, input logic a,
                      input logic bm, input logic lp, input logic cd);
    tx_bit = b; rx_sym = s; rx_amp_ok = a; bin_mode = bm; loop_en = lp; cable_det_n = cd;
    model_edge();
    @(negedge clk);
    chk(tx_sym, e_tx, t_tx, "tx_sym");
    chk({1'b0, rx_data}, {1'b0, e_rx}, t_rx, "rx_data");
    chk({1'b0, sig_det}, {1'b0, e_sd}, t_sd, "sig_det");
  endtask

  function automatic logic [1:0] rand_sym();
    case ($urandom % 3)
      0: return 2'b00;
      1: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic a;
    logic bm, lp, cd;
    int hold;
    void'($urandom(32'd1234));
    // R10: reset state, with active inputs applied
    tx_bit = 1'b1; rx_sym = 2'b01; rx_amp_ok = 1'b1; cable_det_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_sym, 2'b00, "R10", "tx_sym reset");
    chk({1'b0, rx_data}, 2'b00, "R10", "rx_data reset");
    chk({1'b0, sig_det}, 2'b00, "R10", "sig_det reset");
    tx_bit = 1'b0; rx_sym = 2'b00; rx_amp_ok = 1'b0;
    rst_n = 1'b1;

    // R1: a run of ones walks +1,0,-1,0,+1...
    for (int i = 0; i < 9; i++) step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    // R1: zeros hold the level
    for (int i = 0; i < 3; i++) step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    // R3: binary interval freezes phase, then MLT-3 resumes
    step(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    // R2: repeated and changing receive symbols
    step(1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    // R7: three valid then one invalid must not assert; four valid must
    for (int i = 0; i < 3; i++) step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    // R7: three invalid then valid keeps it up; four invalid drops it
    for (int i = 0; i < 3; i++) step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    // R8: fault with detect up and changing symbols
    step(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1);
    // R9 / R5 / R6: loopback over fault, line symbols ignored, binary mode off
    step(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);

    // random mix with modes held over short stretches
    bm = 0; lp = 0; cd = 0; a = 0; hold = 0;
    for (int i = 0; i < NRAND; i++) begin
      if (hold == 0) begin
        bm = ($urandom % 4) == 0;
        lp = ($urandom % 6) == 0;
        cd = ($urandom % 6) == 0;
        hold = 1 + $urandom % 12;
      end
      hold--;
      if (($urandom % 5) == 0) a = !a;
      step(logic'($urandom % 2), rand_sym(), a, bm, lp, cd);
    end

    done = 1;
    summary();
  end
endmodule